// File: doc/BRIEF.md
# Burst Receive Ping-Pong Buffer

This block collects the demodulated bit stream of one receive channel into two message buffers that take turns. Each burst announced by a start pulse is written into the buffer that the host does not currently hold. The incoming bits are packed into 16-bit words, earliest bit in the most significant position. A pulse on the burst-end input closes the buffer and hands it to the host. The host then pulls it out one word per read strobe while the next burst fills the other buffer. A chip with two receive channels uses two instances.

The host always sees the older of the completed buffers. It reads the buffer's valid bit count and its current word directly. When it reads the final word, or when it strobes acknowledge, the buffer is freed and the next completed buffer, if there is one, takes its place. A sticky overflow flag records lost data in two cases: a burst that arrives while both buffers still hold unread messages, and bits beyond the buffer capacity. A maskable interrupt combines the ready flag and the overflow flag.

Top module: `rx_burst_pingpong`

## Requirements
- R1: After reset no buffer is offered to the host (rd_ready=0), ovf=0 and irq=0.
- R2: Bits are packed most significant bit first. The first bit received after a burst start lands in bit 15 of word 0, the seventeenth bit in bit 15 of word 1, and so on. Words are presented to the host in increasing order.
- R3: A final partial word holds its bits in the upper positions, and the unused low bits are zero. While a buffer is offered, rd_bits gives the number of bits stored in it.
- R4: A burst_end pulse during a burst makes the buffer available with rd_ready=1 from the following cycle. Bits with bit_valid outside a burst are not stored.
- R5: Consecutive bursts fill the two buffers alternately. The host is offered the oldest completed buffer first, and a burst can be received into the free buffer while the host holds the other.
- R6: A burst_start that arrives while both buffers hold unread messages sets ovf. The whole new burst is discarded, and both stored messages stay intact.
- R7: Bits beyond CAP_BITS (default 1280) in one burst are discarded and set ovf. The buffer keeps the first CAP_BITS bits and reports rd_bits=CAP_BITS.
- R8: Each rd_req while rd_ready=1 advances rd_data to the next word. A rd_req on the last word (or on a buffer holding no bits) releases the buffer.
- R9: A rd_ack while rd_ready=1 releases the offered buffer at any word position.
- R10: ovf stays set until an ovf_clr pulse clears it.
- R11: irq = (rd_ready AND irq_en[0]) OR (ovf AND irq_en[1]).
- R12: A burst_start during an active burst is ignored, and the burst continues into the same buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_start | input | 1 | Pulse: new burst detected |
| burst_end | input | 1 | Pulse: current burst finished |
| bit_valid | input | 1 | A demodulated bit is present on bit_in |
| bit_in | input | 1 | Demodulated bit |
| rd_req | input | 1 | Host read strobe, advances to the next word |
| rd_ack | input | 1 | Host acknowledge, releases the offered buffer |
| ovf_clr | input | 1 | Clears the overflow flag |
| irq_en | input | 2 | Interrupt enables: bit 0 ready, bit 1 overflow |
| rd_ready | output | 1 | A completed buffer is offered to the host |
| rd_data | output | 16 | Current word of the offered buffer |
| rd_bits | output | CNT_W | Valid bit count of the offered buffer |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Bursts are sent with lengths of 37 bits (partial word), 32 bits (exact words), 20 and 50 bits, and 1290 bits, each with its own bit pattern. These lengths separate errors in padding, word boundaries and capacity clipping. Interleaving bursts with host reads shows that buffer order follows burst order and that the free buffer is chosen correctly. A third burst with both buffers full, a start pulse in the middle of a burst, and stray bits outside any burst each show whether data is dropped, merged or kept as the requirements say.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  localparam int WORD_W  = 16;
  localparam int WORD_SH = 4;   // log2(WORD_W)
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rxpp_packer.sv
module rxpp_packer
  import rxpp_pkg::*;
#(
  parameter int CAP_BITS = 1280,
  parameter int CNT_W    = $clog2(CAP_BITS + 1),
  parameter int AW       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             end_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  output logic             active_o,
  output logic             close_o,
  output logic [CNT_W-1:0] bits_o,
  output logic             cap_ovf_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output word_t            wr_data_o
);
  logic             active_q, active_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  word_t            sh_q, sh_n;
  logic             take, word_full, pad_wr;

  always_comb begin
    take      = active_q && bit_valid_i && (cnt_q < CNT_W'(CAP_BITS));
    cap_ovf_o = active_q && bit_valid_i && (cnt_q == CNT_W'(CAP_BITS));
    cnt_n     = cnt_q + CNT_W'(take);
    sh_n      = take ? {sh_q[WORD_W-2:0], bit_i} : sh_q;
    word_full = take && (cnt_q[WORD_SH-1:0] == '1);
    close_o   = active_q && end_i;
    pad_wr    = close_o && !word_full && (cnt_n[WORD_SH-1:0] != '0);
    wr_en_o   = word_full || pad_wr;
    wr_addr_o = AW'(cnt_q >> WORD_SH);
    wr_data_o = word_full ? sh_n
                          : (sh_n << (5'd16 - {1'b0, cnt_n[WORD_SH-1:0]}));
    bits_o    = cnt_n;
    active_n  = active_q;
    if (start_i) active_n = 1'b1;
    else if (close_o) active_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else begin
      active_q <= active_n;
      if (start_i) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else if (take) begin
        cnt_q <= cnt_n;
        sh_q  <= sh_n;
      end
    end
  end

  assign active_o = active_q;

  // R7: stored bit count never passes capacity
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CAP_BITS));
  // R12: a start pulse does not end an active burst
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !end_i) |=> active_q);
endmodule

// File: rtl/rxpp_store.sv
module rxpp_store
  import rxpp_pkg::*;
#(
  parameter int WORDS = 80,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  word_t         wr_data,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_addr,
  output word_t         rd_data
);
  word_t bank_rd [2];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    word_t mem [WORDS];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == g[0])) mem[wr_addr] <= wr_data;
    end
    assign bank_rd[g] = mem[rd_addr];
  end

  assign rd_data = bank_rd[rd_sel];
endmodule

// File: rtl/rx_burst_pingpong.sv
module rx_burst_pingpong
  import rxpp_pkg::*;
#(
  parameter  int CAP_BITS = 1280,
  localparam int CNT_W    = $clog2(CAP_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_start,
  input  logic             burst_end,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             rd_req,
  input  logic             rd_ack,
  input  logic             ovf_clr,
  input  logic [1:0]       irq_en,
  output logic             rd_ready,
  output logic [15:0]      rd_data,
  output logic [CNT_W-1:0] rd_bits,
  output logic             ovf,
  output logic             irq
);
  localparam int WORDS = (CAP_BITS + WORD_W - 1) / WORD_W;
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic             wr_ptr_q, rd_ptr_q, drop_q, ovf_q;
  logic [1:0]       rdy_q, rdy_n;
  logic [CNT_W-1:0] bits_q [2];
  logic [AW-1:0]    rd_widx_q;

  logic             pk_active, pk_close, pk_capovf, pk_wr_en;
  logic [CNT_W-1:0] pk_bits, nwords;
  logic [AW-1:0]    pk_addr;
  word_t            pk_data;
  logic             busy, start_ok, start_ovf, rd_valid, rd_last, release_c, adv;

  always_comb begin
    busy      = pk_active || drop_q;
    start_ok  = burst_start && !busy && !rdy_q[wr_ptr_q];
    start_ovf = burst_start && !busy &&  rdy_q[wr_ptr_q];
    rd_valid  = rdy_q[rd_ptr_q];
    nwords    = (bits_q[rd_ptr_q] + CNT_W'(WORD_W - 1)) >> WORD_SH;
    rd_last   = (nwords == '0) || (CNT_W'(rd_widx_q) == nwords - CNT_W'(1));
    release_c = rd_valid && (rd_ack || (rd_req && rd_last));
    adv       = rd_valid && rd_req && !release_c;
    rdy_n     = rdy_q;
    if (pk_close)  rdy_n[wr_ptr_q] = 1'b1;
    if (release_c) rdy_n[rd_ptr_q] = 1'b0;
  end

  rxpp_packer #(.CAP_BITS(CAP_BITS), .CNT_W(CNT_W), .AW(AW)) i_packer (
    .clk(clk), .rst_n(rst_n), .start_i(start_ok), .end_i(burst_end),
    .bit_valid_i(bit_valid), .bit_i(bit_in), .active_o(pk_active),
    .close_o(pk_close), .bits_o(pk_bits), .cap_ovf_o(pk_capovf),
    .wr_en_o(pk_wr_en), .wr_addr_o(pk_addr), .wr_data_o(pk_data)
  );

  rxpp_store #(.WORDS(WORDS), .AW(AW)) i_store (
    .clk(clk), .wr_en(pk_wr_en), .wr_sel(wr_ptr_q), .wr_addr(pk_addr),
    .wr_data(pk_data), .rd_sel(rd_ptr_q), .rd_addr(rd_widx_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q  <= 1'b0;
      rd_ptr_q  <= 1'b0;
      drop_q    <= 1'b0;
      ovf_q     <= 1'b0;
      rdy_q     <= '0;
      bits_q[0] <= '0;
      bits_q[1] <= '0;
      rd_widx_q <= '0;
    end else begin
      rdy_q <= rdy_n;
      if (pk_close) begin
        bits_q[wr_ptr_q] <= pk_bits;
        wr_ptr_q         <= !wr_ptr_q;
      end
      if (start_ovf) drop_q <= 1'b1;
      else if (burst_end) drop_q <= 1'b0;
      ovf_q <= (ovf_q && !ovf_clr) || start_ovf || pk_capovf;
      if (release_c) begin
        rd_ptr_q  <= !rd_ptr_q;
        rd_widx_q <= '0;
      end else if (adv) begin
        rd_widx_q <= rd_widx_q + AW'(1);
      end
    end
  end

  assign rd_ready = rd_valid;
  assign rd_bits  = bits_q[rd_ptr_q];
  assign ovf      = ovf_q;
  assign irq      = (rd_valid && irq_en[0]) || (ovf_q && irq_en[1]);

  // R10: overflow flag holds until cleared
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  // R8: read index stays inside a buffer
  a_r8_widx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_widx_q < AW'(WORDS));

  for (genvar g = 0; g < 2; g++) begin : g_chk
    // R6: an unread buffer keeps its content until the host releases it
    a_r6_ready_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_q[g] && !(release_c && rd_ptr_q == g[0])) |=> (rdy_q[g] && $stable(bits_q[g])));
    // R4: a buffer becomes ready only through a burst close
    a_r4_ready_by_close: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_q[g] && !(pk_close && wr_ptr_q == g[0])) |=> !rdy_q[g]);
  end
endmodule

// File: tb/test_rx_burst_pingpong.sv
module test_rx_burst_pingpong;
  localparam int CLK_PERIOD = 10;
  localparam int CAP        = 1280;
  localparam int CW         = $clog2(CAP + 1);

  logic clk, rst_n;
  logic burst_start, burst_end, bit_valid, bit_in, rd_req, rd_ack, ovf_clr;
  logic [1:0] irq_en;
  logic rd_ready, ovf, irq;
  logic [15:0] rd_data;
  logic [CW-1:0] rd_bits;

  int checks = 0, fails = 0;
  bit finished = 0;

  rx_burst_pingpong #(.CAP_BITS(CAP)) i_rx_burst_pingpong (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .burst_end(burst_end),
    .bit_valid(bit_valid), .bit_in(bit_in), .rd_req(rd_req), .rd_ack(rd_ack),
    .ovf_clr(ovf_clr), .irq_en(irq_en), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_bits(rd_bits), .ovf(ovf), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = !clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic pat(int seed, int i);
    return logic'(((i * seed + (i >> 3)) % 3) == 0);
  endfunction

  function automatic logic [15:0] exp_word(int n, int seed, int j);
    logic [15:0] w = '0;
    for (int b = 0; b < 16; b++)
      if (16*j + b < n) w[15-b] = pat(seed, 16*j + b);
    return w;
  endfunction

  task automatic pulse_start();
    burst_start = 1'b1; @(negedge clk); burst_start = 1'b0;
  endtask
  task automatic pulse_end();
    burst_end = 1'b1; @(negedge clk); burst_end = 1'b0;
  endtask
  task automatic push_bits(int n, int seed, int off);
    for (int i = 0; i < n; i++) begin
      bit_valid = 1'b1; bit_in = pat(seed, i + off); @(negedge clk);
    end
    bit_valid = 1'b0; bit_in = 1'b0;
  endtask
  task automatic send_burst(int n, int seed);
    pulse_start(); push_bits(n, seed, 0); pulse_end();
  endtask

  task automatic read_buffer(int n, int seed, string tag);
    int stored = (n > CAP) ? CAP : n;
    int nw = (stored + 15) / 16;
    check(rd_ready === 1'b1, {tag, " ready"}, 32'(rd_ready), 1);
    check(rd_bits == CW'(stored), {tag, " R3 bit count"}, 32'(rd_bits), stored);
    for (int j = 0; j < nw; j++) begin
      check(rd_data === exp_word(n, seed, j), {tag, " R2 word"}, rd_data,
            exp_word(n, seed, j));
      rd_req = 1'b1; @(negedge clk);
    end
    rd_req = 1'b0;
  endtask

  task automatic t_reset();
    check(rd_ready === 1'b0, "R1 rd_ready", 32'(rd_ready), 0);
    check(ovf === 1'b0, "R1 ovf", 32'(ovf), 0);
    check(irq === 1'b0, "R1 irq", 32'(irq), 0);
  endtask

  task automatic t_partial();
    push_bits(5, 9, 0);  // R4: stray bits outside a burst
    send_burst(37, 5);
    read_buffer(37, 5, "R2/R3/R4 37-bit");
    check(rd_ready === 1'b0, "R8 released after last word", 32'(rd_ready), 0);
  endtask

  task automatic t_exact();
    send_burst(32, 11);
    read_buffer(32, 11, "R2 32-bit");
    check(rd_ready === 1'b0, "R8 released", 32'(rd_ready), 0);
  endtask

  task automatic t_alternate();
    send_burst(20, 3);
    send_burst(50, 7);
    read_buffer(20, 3, "R5 first");
    send_burst(24, 13);  // fills freed buffer while host holds the second
    read_buffer(50, 7, "R5 second");
    read_buffer(24, 13, "R5 third");
    check(rd_ready === 1'b0, "R5 all drained", 32'(rd_ready), 0);
    check(ovf === 1'b0, "R5 no overflow", 32'(ovf), 0);
  endtask

  task automatic t_overflow_irq();
    send_burst(20, 17);
    irq_en = 2'b01; #1;
    check(irq === 1'b1, "R11 ready irq", 32'(irq), 1);
    irq_en = 2'b00; #1;
    check(irq === 1'b0, "R11 masked", 32'(irq), 0);
    send_burst(30, 19);
    send_burst(40, 23);  // both unread: discarded
    check(ovf === 1'b1, "R6 ovf set", 32'(ovf), 1);
    irq_en = 2'b10; #1;
    check(irq === 1'b1, "R11 ovf irq", 32'(irq), 1);
    irq_en = 2'b00;
    read_buffer(20, 17, "R6 first intact");
    read_buffer(30, 19, "R6 second intact");
    check(rd_ready === 1'b0, "R6 third burst dropped", 32'(rd_ready), 0);
    repeat (3) @(negedge clk);
    check(ovf === 1'b1, "R10 ovf sticky", 32'(ovf), 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check(ovf === 1'b0, "R10 ovf cleared", 32'(ovf), 0);
  endtask

  task automatic t_capacity();
    send_burst(1290, 29);
    check(ovf === 1'b1, "R7 capacity ovf", 32'(ovf), 1);
    read_buffer(1290, 29, "R7 clipped");
    check(rd_ready === 1'b0, "R7 released", 32'(rd_ready), 0);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
  endtask

  task automatic t_ack();
    send_burst(40, 31);
    check(rd_data === exp_word(40, 31, 0), "R9 word0", rd_data, exp_word(40, 31, 0));
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    check(rd_data === exp_word(40, 31, 1), "R8 advance", rd_data, exp_word(40, 31, 1));
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
    check(rd_ready === 1'b0, "R9 ack releases", 32'(rd_ready), 0);
  endtask

  task automatic t_mid_start();
    pulse_start();
    push_bits(10, 37, 0);
    pulse_start();        // R12: ignored
    push_bits(10, 37, 10);
    pulse_end();
    read_buffer(20, 37, "R12 merged burst");
    check(rd_ready === 1'b0, "R12 single buffer", 32'(rd_ready), 0);
    check(ovf === 1'b0, "R12 no ovf", 32'(ovf), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; burst_start = 0; burst_end = 0; bit_valid = 0; bit_in = 0;
    rd_req = 0; rd_ack = 0; ovf_clr = 0; irq_en = 2'b00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_partial();
    t_exact();
    t_alternate();
    t_overflow_irq();
    t_capacity();
    t_ack();
    t_mid_start();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule